// File: doc/BRIEF.md
# Serial Character Transmitter with Enable Preamble

This block turns characters written into a single holding register into an asynchronous serial bit stream. Each frame is a low start bit, eight or nine data bits sent least significant first, and one high stop bit. Every bit lasts sixteen pulses of an oversampled bit-clock enable, which comes from a divider outside the block. Parity can be inserted in the top data position, and in nine-bit mode the extra data bit is written together with the character.

When the transmit enable is switched on, the shifter first sends a run of high bits as long as one frame. A character that is already waiting goes out only after that run. A flag reports that the holding register is free, and an interrupt request follows it when its enable is set. To give back-to-back frames, the next character is moved into the shifter part-way through the current stop bit. The flag sets at that moment, so software can refill the holding register while the stop bit is still on the line.

Top module: `sertx_core`

## Requirements
- R1: After reset the line `txd` is 1 and `hold_empty` is 1.
- R2: In the cycle after `tx_en` goes from 0 to 1, the shifter starts a run of all-ones bits, each bit 16 `tick16` pulses long. The run is 10 bits when `nine_bit`=0 and 11 bits when `nine_bit`=1. A waiting character is sent only after the last bit of the run.
- R3: A frame on `txd` is a 0 start bit, then the data bits least significant first (8 bits, or 9 when `nine_bit`=1), then one 1 stop bit. Each bit lasts 16 `tick16` pulses.
- R4: With `par_en`=1, the highest data position carries parity: bit 7 in 8-bit mode, bit 8 in 9-bit mode. It is the XOR of the lower data bits, inverted when `par_odd`=1 (0 = even, 1 = odd).
- R5: With `nine_bit`=1 and `par_en`=0, data bit 8 of the frame is the `wr_bit8` value captured with the character.
- R6: When a character is waiting during a stop bit, it moves into the shifter on the 9th `tick16` pulse of that stop bit, and `hold_empty` sets then. Its start bit begins right after the 16th pulse of the stop bit.
- R7: While the shifter is idle, `txd` is 1. If a character is waiting while the shifter is idle and `tx_en`=1, it moves into the shifter in the next cycle, and its start bit begins at once.
- R8: `hold_empty` sets on every holding-to-shifter transfer. A `wr_stb` pulse while `hold_empty`=1 captures `wr_data`/`wr_bit8` and clears the flag. A `wr_stb` pulse while `hold_empty`=0 is ignored: the flag stays 0 and the waiting character is unchanged.
- R9: While `tx_en`=0 no transfer takes place, so a waiting character stays waiting. A frame or run already in the shifter still completes.
- R10: `tx_irq` is 1 exactly when `irq_en`=1 and `hold_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_en | input | 1 | Transmitter enable; a rising edge starts the all-ones run |
| nine_bit | input | 1 | 1 = nine data bits, 0 = eight |
| par_en | input | 1 | Parity in the top data position |
| par_odd | input | 1 | Parity type, 1 = odd, 0 = even |
| irq_en | input | 1 | Enables the interrupt request |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character bits 7..0 |
| wr_bit8 | input | 1 | Ninth character bit |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register is free |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A write from software and the holding-to-shifter transfer can fall in the same cycle. That cycle is the only place where the rule "a write only lands while the flag is set" decides what goes on the line. The bench provokes it by holding `wr_stb` high for thousands of cycles while `wr_data` changes every cycle. Transfers then land on the 9th stop-bit pulse and at the end of the preamble with a write already present. A behavioural queue model in the bench predicts which value was captured and which was dropped, and every cycle the line and the flag are compared with it. A rising `tx_en` that coincides with a write is also exercised.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W_DEF  = 8;
    localparam int OVS_DEF     = 16;
    localparam int HANDOFF_DEF = 9;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_PREAMBLE,
        SH_FRAME
    } sh_mode_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } fmt_t;

    function automatic int frame_bits(input logic nine, input int dw);
        return nine ? dw + 3 : dw + 2;
    endfunction

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
    parameter int DATA_W = sertx_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wbit,
    input  logic              xfer,
    output logic [DATA_W-1:0] data_q,
    output logic              bit_q,
    output logic              empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            bit_q  <= 1'b0;
            empty  <= 1'b1;
        end else if (xfer) begin
            empty <= 1'b1;
        end else if (wr && empty) begin
            data_q <= wdata;
            bit_q  <= wbit;
            empty  <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
    parameter int DATA_W = sertx_pkg::DATA_W_DEF,
    localparam int FRAME_W = DATA_W + 3
) (
    input  logic [DATA_W-1:0] data,
    input  logic              ext_bit,
    input  sertx_pkg::fmt_t   fmt,
    output logic [FRAME_W-1:0] frame
);
    logic [DATA_W:0] body;
    logic            par;

    always_comb begin
        // unused ninth slot in 8-bit mode reads as the stop level
        body = {fmt.nine ? ext_bit : 1'b1, data};
        par  = fmt.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (fmt.nine || (i < DATA_W - 1)) par = par ^ data[i];
        end
        if (fmt.par_en) begin
            if (fmt.nine) body[DATA_W] = par;
            else          body[DATA_W-1] = par;
        end
        frame = {1'b1, body, 1'b0};
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int DATA_W  = sertx_pkg::DATA_W_DEF,
    parameter int OVS     = sertx_pkg::OVS_DEF,
    parameter int HANDOFF = sertx_pkg::HANDOFF_DEF,
    localparam int FRAME_W = DATA_W + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               tx_en,
    input  logic               nine,
    input  logic               pend,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               xfer,
    output logic               txd
);
    import sertx_pkg::*;

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] LEN8 = CNT_W'(frame_bits(1'b0, DATA_W));
    localparam logic [CNT_W-1:0] LEN9 = CNT_W'(frame_bits(1'b1, DATA_W));
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_TAP  = SUB_W'(HANDOFF - 1);

    sh_mode_e           mode;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;
    logic [SUB_W-1:0]   sub;
    logic               tail;
    logic               en_q;
    logic               en_rise;
    logic               bit_end;
    logic               at_tap;
    logic               may_load;
    logic [CNT_W-1:0]   cur_len;

    assign en_rise = tx_en && !en_q;
    assign cur_len = nine ? LEN9 : LEN8;

    always_comb begin
        bit_end  = tick && (sub == SUB_LAST);
        at_tap   = tick && (sub == SUB_TAP);
        may_load = tx_en && pend && !en_rise;
        xfer     = 1'b0;
        if (may_load) begin
            if (mode == SH_IDLE) begin
                xfer = 1'b1;
            end else if (!tail && left == ONE) begin
                if (mode == SH_PREAMBLE && bit_end) xfer = 1'b1;
                if (mode == SH_FRAME && at_tap)     xfer = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= tx_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= SH_IDLE;
            shreg <= '1;
            left  <= '0;
            sub   <= '0;
            tail  <= 1'b0;
        end else if (en_rise) begin
            mode  <= SH_PREAMBLE;
            shreg <= '1;
            left  <= cur_len;
            sub   <= '0;
            tail  <= 1'b0;
        end else if (mode == SH_IDLE) begin
            if (xfer) begin
                mode  <= SH_FRAME;
                shreg <= frame_in;
                left  <= cur_len;
                sub   <= '0;
            end
        end else if (tick) begin
            sub <= bit_end ? '0 : sub + 1'b1;
            if (xfer) begin
                // mid-stop handoff keeps the stop level until the bit ends
                tail  <= (mode == SH_FRAME);
                mode  <= SH_FRAME;
                shreg <= frame_in;
                left  <= cur_len;
            end else if (tail) begin
                if (bit_end) tail <= 1'b0;
            end else if (bit_end) begin
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - 1'b1;
                if (left == ONE) mode <= SH_IDLE;
            end
        end
    end

    assign txd = (mode == SH_IDLE || tail) ? 1'b1 : shreg[0];
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
    parameter int DATA_W  = sertx_pkg::DATA_W_DEF,
    parameter int OVS     = sertx_pkg::OVS_DEF,
    parameter int HANDOFF = sertx_pkg::HANDOFF_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              irq_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_irq
);
    import sertx_pkg::*;

    localparam int FRAME_W = DATA_W + 3;

    fmt_t               fmt;
    logic [DATA_W-1:0]  h_data;
    logic               h_bit;
    logic               xfer;
    logic [FRAME_W-1:0] frame;

    assign fmt = '{nine: nine_bit, par_en: par_en, par_odd: par_odd};

    sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_stb),
        .wdata  (wr_data),
        .wbit   (wr_bit8),
        .xfer   (xfer),
        .data_q (h_data),
        .bit_q  (h_bit),
        .empty  (hold_empty)
    );

    sertx_framer #(.DATA_W(DATA_W)) u_frm (
        .data    (h_data),
        .ext_bit (h_bit),
        .fmt     (fmt),
        .frame   (frame)
    );

    sertx_shifter #(.DATA_W(DATA_W), .OVS(OVS), .HANDOFF(HANDOFF)) u_sh (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .tx_en    (tx_en),
        .nine     (nine_bit),
        .pend     (!hold_empty),
        .frame_in (frame),
        .xfer     (xfer),
        .txd      (txd)
    );

    assign tx_irq = irq_en && hold_empty;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic irq_en,
    input logic wr_stb,
    input logic txd,
    input logic hold_empty,
    input logic tx_irq
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (txd && hold_empty));

    // R2
    a_r2_preamble_high: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |=> txd);

    // R8
    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && hold_empty) |=> !hold_empty);

    // R9
    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !hold_empty) |=> !hold_empty);

    // R10
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> (hold_empty && irq_en));

    // R10
    a_r10_irq_when_set: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && irq_en) |-> tx_irq);
endmodule

bind sertx_core sertx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .irq_en     (irq_en),
    .wr_stb     (wr_stb),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_irq     (tx_irq)
);

// File: tb/sim_sertx_core.sv
`timescale 1ns/1ps
module sim_sertx_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bit8 = 1'b0;
    logic       txd;
    logic       hold_empty;
    logic       tx_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sertx_core u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .tx_en(tx_en),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .irq_en(irq_en), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_bit8(wr_bit8), .txd(txd), .hold_empty(hold_empty),
        .tx_irq(tx_irq)
    );

    // ---------------- reference model ----------------
    // kind: 0 preamble bit, 1 start/data bit, 2 stop bit
    int q_lvl[$];
    int q_kind[$];
    int tcnt;
    bit m_empty;
    int m_d;
    int m_b8;
    bit en_prev;
    bit m_xfer;
    bit m_ok;
    int popped;

    function automatic void push_frame();
        int n;
        int v;
        int p;
        n = nine_bit ? 9 : 8;
        v = nine_bit ? ((m_b8 << 8) | m_d) : m_d;
        if (par_en) begin
            p = par_odd ? 1 : 0;
            for (int i = 0; i < n - 1; i++) p = p ^ ((v >> i) & 1);
            v = (v & ~(1 << (n - 1))) | (p << (n - 1));
        end
        q_lvl.push_back(0); q_kind.push_back(1);
        for (int i = 0; i < n; i++) begin
            q_lvl.push_back((v >> i) & 1);
            q_kind.push_back(1);
        end
        q_lvl.push_back(1); q_kind.push_back(2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q_lvl.delete(); q_kind.delete();
            tcnt = 0; m_empty = 1'b1; m_d = 0; m_b8 = 0; en_prev = 1'b0;
        end else begin
            m_xfer = 1'b0;
            m_ok = tx_en && !m_empty;
            if (tx_en && !en_prev) begin
                q_lvl.delete(); q_kind.delete();
                for (int i = 0; i < (nine_bit ? 11 : 10); i++) begin
                    q_lvl.push_back(1); q_kind.push_back(0);
                end
                tcnt = 0;
            end else if (q_lvl.size() == 0) begin
                if (m_ok) begin push_frame(); tcnt = 0; m_xfer = 1'b1; end
            end else if (tick16) begin
                tcnt++;
                if (tcnt == 16) begin
                    popped = q_kind.pop_front();
                    void'(q_lvl.pop_front());
                    tcnt = 0;
                    if (q_lvl.size() == 0 && popped == 0 && m_ok) begin
                        push_frame(); m_xfer = 1'b1;
                    end
                end else if (tcnt == 9 && q_lvl.size() == 1 && q_kind[0] == 2 && m_ok) begin
                    push_frame(); m_xfer = 1'b1;
                end
            end
            if (m_xfer) m_empty = 1'b1;
            else if (wr_stb && m_empty) begin
                m_empty = 1'b0; m_d = int'(wr_data); m_b8 = int'(wr_bit8);
            end
            en_prev = tx_en;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 1 ns after the edge
    initial begin
        int exp_txd;
        string tag;
        forever begin
            @(posedge clk);
            #1;
            if (!rst && !done) begin
                if (q_lvl.size() == 0) begin exp_txd = 1; tag = "R7 idle line"; end
                else begin
                    exp_txd = q_lvl[0];
                    if (q_kind[0] == 0)      tag = "R2 preamble bit";
                    else if (q_kind[0] == 2) tag = "R6 stop bit";
                    else                     tag = "R3 R4 R5 frame bit";
                end
                chk(int'(txd) == exp_txd, tag, int'(txd), exp_txd);
                chk(hold_empty == m_empty, "R8 empty flag", int'(hold_empty), int'(m_empty));
                chk(tx_irq == (irq_en && m_empty), "R10 irq", int'(tx_irq), int'(irq_en && m_empty));
            end
        end
    end

    // bit-clock enable: one pulse every 3 cycles
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick16 = (div == 0);
            div = (div + 1) % 3;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input int d, input bit b8);
        for (int i = 0; i < 20000 && !hold_empty; i++) step(1);
        wr_stb = 1'b1; wr_data = 8'(d); wr_bit8 = b8;
        step(1);
        wr_stb = 1'b0;
    endtask

    task automatic quiet();
        for (int i = 0; i < 20000 && !(q_lvl.size() == 0 && m_empty); i++) step(1);
        step(3);
    endtask

    initial begin
        step(5);
        rst = 1'b0;
        step(1);
        chk(txd == 1'b1, "R1 reset line", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1 reset flag", int'(hold_empty), 1);

        // 8-bit, no parity; data waits behind the preamble
        irq_en = 1'b1;
        put(8'hA5, 1'b0);
        tx_en = 1'b1;
        step(40);
        wr_stb = 1'b1; wr_data = 8'h3C; step(1); wr_stb = 1'b0;
        step(1);
        chk(hold_empty == 1'b0, "R8 write while full ignored", int'(hold_empty), 0);
        put(8'h5A, 1'b0);
        put(8'hF0, 1'b0);
        quiet();

        // parity variants (R4)
        par_en = 1'b1; par_odd = 1'b0;
        put(8'h13, 1'b0); put(8'h7F, 1'b0);
        quiet();
        par_odd = 1'b1;
        put(8'h13, 1'b0); put(8'h00, 1'b0);
        quiet();

        // nine-bit data (R5), then with parity
        par_en = 1'b0; nine_bit = 1'b1;
        put(8'h81, 1'b1); put(8'h81, 1'b0);
        quiet();
        par_en = 1'b1; par_odd = 1'b0;
        put(8'hC3, 1'b0); put(8'hC2, 1'b1);
        quiet();

        // R9: disable mid-frame with a character waiting
        par_en = 1'b0; nine_bit = 1'b0;
        put(8'h96, 1'b0);
        put(8'h69, 1'b0);
        step(150);
        tx_en = 1'b0;
        step(700);
        chk(hold_empty == 1'b0, "R9 waiting char held", int'(hold_empty), 0);
        chk(txd == 1'b1, "R9 line idle after frame", int'(txd), 1);
        // re-enable in 9-bit mode: 11-bit preamble first (R2)
        nine_bit = 1'b1;
        tx_en = 1'b1;
        step(1);
        chk(hold_empty == 1'b0, "R2 data waits for preamble", int'(hold_empty), 0);
        quiet();

        // write strobe held high: writes collide with transfers (R6 R8)
        nine_bit = 1'b0; irq_en = 1'b0;
        wr_stb = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            wr_data = 8'(i * 7 + 1); wr_bit8 = i[0];
            step(1);
        end
        wr_stb = 1'b0;
        quiet();

        // tx_en rise together with a write
        tx_en = 1'b0; step(5);
        tx_en = 1'b1; wr_stb = 1'b1; wr_data = 8'hE7;
        step(1);
        wr_stb = 1'b0;
        quiet();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule